// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This controller sits between an on-chip requester and a 1M x 16 asynchronous DRAM whose row and column addresses share ten address pins. A request carries a 20-bit word address, a read/write flag, two byte enables and write data, and it is offered with a valid/ready handshake. The controller splits the address into a 10-bit row (upper bits) and a 10-bit column (lower bits). It drives the row strobe, the two byte-lane column strobes, write enable and output enable, and it steers the shared data bus through a separate output-enable signal.

After a row has been opened, the row strobe stays low. Further requests to the same row run as short column-only cycles. A request to another row, a row that has been open close to the longest allowed strobe-low time, or, when the idle-close input is set, a cycle with no request, closes the page. The controller then waits out the precharge time before it opens a new row. Every analog timing is a parameter in whole clock cycles. Read data comes back with a one-cycle response pulse.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is held (synchronous, active low) and in the first cycle after it, ras_n, both CAS strobes, we_n and oe_n are high, dq_oe is low, req_ready is high and rsp_valid is low.
- R2: When ras_n falls, dram_a carries req_addr[19:10] of the accepted request. When a CAS strobe falls, dram_a carries req_addr[9:0].
- R3: The first CAS fall after a row opens comes exactly T_RCD_CYC+1 cycles after ras_n falls.
- R4: For a write, we_n is low at least one cycle before the CAS fall and stays low while CAS is low. dq_oe is high and dq_out equals the write data during that time. oe_n stays high whenever we_n is low.
- R5: dram_lcas_n goes low if and only if req_be[0] is set, and dram_ucas_n if and only if req_be[1] is set. Enabled lanes fall in the same cycle and stay low for exactly T_CAS_CYC cycles. A write changes only the enabled bytes.
- R6: For a read, rsp_rdata equals dram_dq_in on the enabled bytes. rsp_valid is a single-cycle pulse T_RCD_CYC+T_CAS_CYC+1 cycles after acceptance from a closed page, or T_CAS_CYC+1 cycles after acceptance into an open page.
- R7: Requests to the row that is already open are accepted without ras_n rising. With dram_close_idle low, the page stays open while no request is offered.
- R8: A request to a different row closes the page. ras_n stays high at least T_RP_CYC cycles before the next fall.
- R9: Each ras_n low period lasts between T_RAS_MIN_CYC and RAS_MAX_CYC cycles. A long stream of same-row requests is broken by a page close.
- R10: A CAS strobe is low only while ras_n is low. Both CAS strobes stay high at least 2 cycles between column cycles within one page.
- R11: With dram_close_idle high, an open page with no request offered is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dram_close_idle | input | 1 | Close the open page when no request is offered |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address: row in [19:10], column in [9:0] |
| req_be | input | 2 | Byte enables: bit 0 lower byte, bit 1 upper byte |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_rdata | output | 16 | Read data |
| dram_a | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_lcas_n | output | 1 | Lower-byte column strobe, active low |
| dram_ucas_n | output | 1 | Upper-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 16 | Data returned by the DRAM |

## Verification
An accepted request from a closed page drops ras_n in the next cycle. The CAS fall comes T_RCD_CYC+1 cycles later, and the response comes T_CAS_CYC cycles after that. A page-hit request drops CAS T_CAS_CYC cycles before its response, and the response comes T_CAS_CYC+1 cycles after acceptance. The bench samples every output on the falling clock edge and keeps a cycle index. It timestamps each strobe edge and each handshake, then compares the differences with these counts. It does not assume a fixed cycle for any event. Precharge and strobe-low lengths are measured in the same way. A behavioural DRAM model in the bench stores the bytes that were strobed, and a separate scoreboard predicts every read result.

// File: rtl/fpm_pkg.sv
// Shared types for the page-mode DRAM controller.
// Assumes: one outstanding operation at a time.
package fpm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // row strobe high, precharge already satisfied
        ST_ACT,    // row strobe low, row address held
        ST_COL,    // column address set up, CAS high
        ST_CAS,    // byte-lane CAS strobes low
        ST_OPEN,   // page open, waiting for the next request
        ST_PRE     // row strobe high, precharge running
    } fpm_state_t;

    // Largest of three cycle counts, used to size the shared counter.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/fpm_delay_cnt.sv
// Down-counter that times one interval at a time.
// Assumes: load_val is the interval length minus one; done is high on its last cycle.
module fpm_delay_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    // Load on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/fpm_page_age.sv
// Counts cycles since the row strobe fell.
// Flags the minimum low time and the point where the page must be closed.
// Assumes: clear is pulsed on the edge that opens a row.
module fpm_page_age #(
    parameter int W       = 10,
    parameter int MIN_AGE = 4,
    parameter int LIMIT   = 900
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic min_met,
    output logic expired
);
    localparam logic [W-1:0] SAT = '1;
    logic [W-1:0] age;

    // Restart on row open, saturating increment while the row is low.
    always_ff @(posedge clk) begin
        if (!rst_n)                  age <= '0;
        else if (clear)              age <= '0;
        else if (run && age != SAT)  age <= age + 1'b1;
    end

    assign min_met = (age >= W'(MIN_AGE));
    assign expired = (age >= W'(LIMIT));
endmodule

// File: rtl/fpm_addr_mux.sv
// Puts the row or the column on the shared address pins.
// Assumes: the narrower field is zero-extended to the pin width.
module fpm_addr_mux #(
    parameter int ROW_W = 10,
    parameter int COL_W = 10,
    parameter int PIN_W = 10
) (
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic             sel_col,
    output logic [PIN_W-1:0] pins
);
    logic [PIN_W-1:0] row_x, col_x;

    // Widen each field to the pin width, choosing the form by parameter.
    generate
        if (ROW_W == PIN_W) begin : g_row_eq
            assign row_x = row;
        end else begin : g_row_pad
            assign row_x = {{(PIN_W-ROW_W){1'b0}}, row};
        end
        if (COL_W == PIN_W) begin : g_col_eq
            assign col_x = col;
        end else begin : g_col_pad
            assign col_x = {{(PIN_W-COL_W){1'b0}}, col};
        end
    endgenerate

    assign pins = sel_col ? col_x : row_x;
endmodule

// File: rtl/fpm_dram_ctrl.sv
// Page-mode controller for a 1M x 16 multiplexed-address asynchronous DRAM.
// Keeps a row open across same-row requests and uses the two CAS strobes as
// byte-lane selects. All analog timings are parameters in clock cycles.
// Assumes: every T_* parameter is at least 1, the byte enables are non-zero,
// and refresh is scheduled elsewhere.
module fpm_dram_ctrl #(
    parameter int ROW_W         = 10,
    parameter int COL_W         = 10,
    parameter int DATA_W        = 16,
    parameter int T_RCD_CYC     = 2,
    parameter int T_CAS_CYC     = 2,
    parameter int T_RP_CYC      = 3,
    parameter int T_RAS_MIN_CYC = 5,
    parameter int RAS_MAX_CYC   = 1000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   dram_close_idle,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [1:0]             req_be,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   rsp_valid,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0] dram_a,
    output logic                   dram_ras_n,
    output logic                   dram_lcas_n,
    output logic                   dram_ucas_n,
    output logic                   dram_we_n,
    output logic                   dram_oe_n,
    output logic [DATA_W-1:0]      dram_dq_out,
    output logic                   dram_dq_oe,
    input  logic [DATA_W-1:0]      dram_dq_in
);
    import fpm_pkg::*;

    localparam int ADDR_W  = ROW_W + COL_W;
    localparam int PIN_W   = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int CNT_W   = $clog2(max3(T_RCD_CYC, T_CAS_CYC, T_RP_CYC) + 1);
    localparam int AGE_W   = $clog2(RAS_MAX_CYC + 1);
    localparam int GUARD   = T_CAS_CYC + 3;             // worst extension after a late hit
    localparam int AGE_LIM = RAS_MAX_CYC - GUARD;
    localparam int MIN_AGE = T_RAS_MIN_CYC - 1;

    fpm_state_t          state, state_nx;
    logic [ROW_W-1:0]    cur_row;
    logic [COL_W-1:0]    op_col;
    logic [1:0]          op_be;
    logic                op_write;
    logic [DATA_W-1:0]   op_wdata;
    logic                cnt_load, cnt_done;
    logic [CNT_W-1:0]    cnt_val;
    logic                age_min, age_exp;
    logic                row_hit, accept, page_close;
    logic [1:0]          lane_low;

    // Same-row request while the page is still young enough.
    assign row_hit   = (state == ST_OPEN) && (req_addr[ADDR_W-1:COL_W] == cur_row) && !age_exp;
    assign req_ready = (state == ST_IDLE) || row_hit;
    assign accept    = req_valid && req_ready;

    // Reasons to leave an open page, gated by the minimum row-low time.
    assign page_close = age_min && (age_exp || (req_valid && !row_hit) ||
                                    (!req_valid && dram_close_idle));

    // Next state and interval counter loads.
    always_comb begin
        state_nx = state;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (state)
            ST_IDLE: if (accept) begin
                state_nx = ST_ACT;
                cnt_load = 1'b1;
                cnt_val  = CNT_W'(T_RCD_CYC - 1);
            end
            ST_ACT:  if (cnt_done) state_nx = ST_COL;
            ST_COL: begin
                state_nx = ST_CAS;
                cnt_load = 1'b1;
                cnt_val  = CNT_W'(T_CAS_CYC - 1);
            end
            ST_CAS:  if (cnt_done) state_nx = ST_OPEN;
            ST_OPEN: if (accept) begin
                state_nx = ST_COL;
            end else if (page_close) begin
                state_nx = ST_PRE;
                cnt_load = 1'b1;
                cnt_val  = CNT_W'(T_RP_CYC - 1);
            end
            ST_PRE:  if (cnt_done) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Capture the accepted operation; the row only when a page opens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_row  <= '0;
            op_col   <= '0;
            op_be    <= '0;
            op_write <= 1'b0;
            op_wdata <= '0;
        end else if (accept) begin
            if (state == ST_IDLE) cur_row <= req_addr[ADDR_W-1:COL_W];
            op_col   <= req_addr[COL_W-1:0];
            op_be    <= req_be;
            op_write <= req_write;
            op_wdata <= req_wdata;
        end
    end

    // Read capture at the last CAS-low cycle, with a one-cycle response pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= (state == ST_CAS) && cnt_done && !op_write;
            if ((state == ST_CAS) && cnt_done && !op_write) rsp_rdata <= dram_dq_in;
        end
    end

    fpm_delay_cnt #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val), .done(cnt_done)
    );

    fpm_page_age #(.W(AGE_W), .MIN_AGE(MIN_AGE), .LIMIT(AGE_LIM)) u_age (
        .clk(clk), .rst_n(rst_n),
        .clear((state == ST_IDLE) && accept),
        .run(!dram_ras_n),
        .min_met(age_min), .expired(age_exp)
    );

    fpm_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .PIN_W(PIN_W)) u_amux (
        .row(cur_row), .col(op_col),
        .sel_col((state == ST_COL) || (state == ST_CAS)),
        .pins(dram_a)
    );

    // One column strobe per byte lane.
    generate
        for (genvar i = 0; i < 2; i++) begin : g_lane
            assign lane_low[i] = (state == ST_CAS) && op_be[i];
        end
    endgenerate

    assign dram_ras_n  = (state == ST_IDLE) || (state == ST_PRE);
    assign dram_lcas_n = !lane_low[0];
    assign dram_ucas_n = !lane_low[1];
    assign dram_dq_oe  = op_write && ((state == ST_COL) || (state == ST_CAS));
    assign dram_we_n   = !dram_dq_oe;
    assign dram_oe_n   = !(!op_write && (state == ST_CAS));
    assign dram_dq_out = op_wdata;

endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
// Protocol checker for the page-mode controller, attached by bind.
// Measures strobe intervals with counters so long windows are not unrolled.
module fpm_dram_ctrl_chk #(
    parameter int T_RP_CYC    = 3,
    parameter int RAS_MAX_CYC = 1000
) (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic lcas_n,
    input logic ucas_n,
    input logic we_n,
    input logic oe_n,
    input logic dq_oe,
    input logic rsp_valid
);
    int hi_cnt;
    int lo_cnt;

    // Length of the current row-strobe high and low periods.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= T_RP_CYC;
            lo_cnt <= 0;
        end else begin
            hi_cnt <= ras_n  ? ((hi_cnt < T_RP_CYC + 2) ? hi_cnt + 1 : hi_cnt) : 0;
            lo_cnt <= !ras_n ? ((lo_cnt < RAS_MAX_CYC + 2) ? lo_cnt + 1 : lo_cnt) : 0;
        end
    end

    // R8
    precharge_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> hi_cnt >= T_RP_CYC);

    // R9
    ras_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> lo_cnt < RAS_MAX_CYC);

    // R10
    cas_under_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcas_n || !ucas_n) |-> !ras_n);

    // R5
    lower_lane_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcas_n) |-> (ucas_n || $fell(ucas_n)));

    // R5
    upper_lane_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ucas_n) |-> (lcas_n || $fell(lcas_n)));

    // R4
    early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($fell(lcas_n) || $fell(ucas_n)) && !we_n) |-> ($past(!we_n) && dq_oe));

    // R4
    no_oe_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> oe_n);

    // R6
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(
    .T_RP_CYC(T_RP_CYC), .RAS_MAX_CYC(RAS_MAX_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .lcas_n(dram_lcas_n),
    .ucas_n(dram_ucas_n), .we_n(dram_we_n), .oe_n(dram_oe_n),
    .dq_oe(dram_dq_oe), .rsp_valid(rsp_valid)
);

// File: tb/tb_fpm_dram_ctrl.sv
// Self-checking bench: directed corner cases plus seeded random traffic.
// Includes a behavioural DRAM model and a scoreboard.
module tb_fpm_dram_ctrl;
    localparam int T_RCD = 2, T_CAS = 2, T_RP = 3, T_RAS_MIN = 5, RAS_MAX = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        close_idle = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [1:0]  req_be = 2'b11;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata, dq_out, dq_in, dq_model;
    logic [9:0]  dram_a;
    logic        ras_n, lcas_n, ucas_n, we_n, oe_n, dq_oe;

    int checks = 0, errs = 0;

    fpm_dram_ctrl #(
        .T_RCD_CYC(T_RCD), .T_CAS_CYC(T_CAS), .T_RP_CYC(T_RP),
        .T_RAS_MIN_CYC(T_RAS_MIN), .RAS_MAX_CYC(RAS_MAX)
    ) dut (
        .clk(clk), .rst_n(rst_n), .dram_close_idle(close_idle),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_a(dram_a),
        .dram_ras_n(ras_n), .dram_lcas_n(lcas_n), .dram_ucas_n(ucas_n),
        .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_dq_out(dq_out),
        .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
    );

    always #5 clk = ~clk;

    assign dq_in = oe_n ? 16'h0000 : dq_model;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard and DRAM model storage.
    logic [15:0] sb_mem  [logic [19:0]];
    logic [15:0] dev_mem [logic [19:0]];

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                          input logic [1:0] be);
        return {be[1] ? nw[15:8] : old[15:8], be[0] ? nw[7:0] : old[7:0]};
    endfunction

    function automatic logic [15:0] sb_rd(input logic [19:0] a);
        return sb_mem.exists(a) ? sb_mem[a] : 16'h0000;
    endfunction

    function automatic logic [15:0] dev_rd(input logic [19:0] a);
        return dev_mem.exists(a) ? dev_mem[a] : 16'h0000;
    endfunction

    // Monitor state.
    int cyc = 0, ras_fall_cyc = 0, ras_rise_cyc = -100, cas_fall_cyc = 0, cas_rise_cyc = 0;
    int ras_falls = 0, rd_acc_cyc = 0, acc_cyc = 0;
    bit first_cas = 1'b0;
    logic p_ras = 1'b1, p_l = 1'b1, p_u = 1'b1, p_we = 1'b1;
    logic [9:0]  cur_row = '0;
    logic        acc_wr = 1'b0;
    logic [19:0] acc_addr = '0;
    logic [1:0]  acc_be = 2'b11;
    logic [15:0] acc_wd = '0, exp_rd = '0, last_rd = '0;
    logic [1:0]  exp_be = 2'b11;

    // Sample on the falling edge, timestamp strobe edges and compare intervals.
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (p_ras && !ras_n) begin
                chk(dram_a == acc_addr[19:10], "R2 row on ras fall", dram_a, acc_addr[19:10]);
                chk(cyc - ras_rise_cyc >= T_RP, "R8 precharge length", cyc - ras_rise_cyc, T_RP);
                ras_fall_cyc = cyc; first_cas = 1'b1; cur_row = dram_a; ras_falls++;
            end
            if (!p_ras && ras_n) begin
                chk(cyc - ras_fall_cyc >= T_RAS_MIN && cyc - ras_fall_cyc <= RAS_MAX,
                    "R9 ras low length", cyc - ras_fall_cyc, RAS_MAX);
                ras_rise_cyc = cyc;
            end
            if ((!lcas_n || !ucas_n) && p_l && p_u) begin
                chk({!ucas_n, !lcas_n} == acc_be, "R5 lane strobes", {!ucas_n, !lcas_n}, acc_be);
                chk(dram_a == acc_addr[9:0], "R2 column on cas fall", dram_a, acc_addr[9:0]);
                chk(!ras_n, "R10 cas under ras", ras_n, 0);
                if (first_cas)
                    chk(cyc - ras_fall_cyc == T_RCD + 1, "R3 ras to cas", cyc - ras_fall_cyc, T_RCD + 1);
                else
                    chk(cyc - cas_rise_cyc >= 2, "R10 cas precharge", cyc - cas_rise_cyc, 2);
                first_cas = 1'b0;
                if (acc_wr) begin
                    chk(!we_n && !p_we && dq_oe && oe_n && dq_out == acc_wd,
                        "R4 early write", dq_out, acc_wd);
                    dev_mem[{cur_row, dram_a}] = merge(dev_rd({cur_row, dram_a}), dq_out,
                                                       {!ucas_n, !lcas_n});
                end else begin
                    dq_model = dev_rd({cur_row, dram_a});
                end
                cas_fall_cyc = cyc;
            end
            if (lcas_n && ucas_n && (!p_l || !p_u)) begin
                chk(cyc - cas_fall_cyc == T_CAS, "R5 cas low length", cyc - cas_fall_cyc, T_CAS);
                cas_rise_cyc = cyc;
            end
            if (rsp_valid) begin
                logic [15:0] m;
                int lat;
                m = {{8{exp_be[1]}}, {8{exp_be[0]}}};
                lat = (ras_fall_cyc == rd_acc_cyc) ? T_RCD + T_CAS + 1 : T_CAS + 1;
                chk((rsp_rdata & m) == (exp_rd & m), "R6 read data", rsp_rdata & m, exp_rd & m);
                chk(cyc - rd_acc_cyc == lat, "R6 read latency", cyc - rd_acc_cyc, lat);
                last_rd = rsp_rdata;
            end
            if (req_valid && req_ready) begin
                acc_cyc = cyc + 1; acc_wr = req_write; acc_addr = req_addr;
                acc_be = req_be; acc_wd = req_wdata;
                if (req_write) begin
                    sb_mem[req_addr] = merge(sb_rd(req_addr), req_wdata, req_be);
                end else begin
                    exp_rd = sb_rd(req_addr); exp_be = req_be; rd_acc_cyc = cyc + 1;
                end
            end
            p_ras = ras_n; p_l = lcas_n; p_u = ucas_n; p_we = we_n;
        end
    end

    // Offer one request; called and returning just after a rising edge.
    task automatic req(input bit wr, input logic [19:0] a, input logic [1:0] be,
                       input logic [15:0] d);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #2;
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #2_000_000;
        checks++; errs++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int f0;
        // R1 reset state during and after reset
        repeat (3) @(posedge clk);
        #2;
        chk(ras_n && lcas_n && ucas_n && we_n && oe_n && !dq_oe && req_ready && !rsp_valid,
            "R1 reset state", {ras_n, lcas_n, ucas_n, we_n, oe_n, dq_oe, req_ready, rsp_valid},
            8'b11111010);
        @(posedge clk); #2;
        rst_n = 1'b1;
        @(posedge clk); #2;
        chk(ras_n && lcas_n && ucas_n && !dq_oe && req_ready, "R1 first cycle after reset",
            {ras_n, lcas_n, ucas_n, dq_oe, req_ready}, 5'b11101);

        // R7 same-row stream opens the row once and stays open when idle
        f0 = ras_falls;
        req(1, {10'h011, 10'h001}, 2'b11, 16'hA1A1);
        req(1, {10'h011, 10'h002}, 2'b11, 16'hB2B2);
        req(0, {10'h011, 10'h001}, 2'b11, 16'h0);
        req(0, {10'h011, 10'h002}, 2'b11, 16'h0);
        idle(10);
        chk(ras_falls - f0 == 1, "R7 single row open for hits", ras_falls - f0, 1);
        chk(!ras_n, "R7 page held open while idle", ras_n, 0);

        // R11 idle close option
        close_idle = 1'b1;
        idle(10);
        chk(ras_n, "R11 page closed when idle", ras_n, 1);
        close_idle = 1'b0;

        // R5 byte-lane write: lower byte only, then read back
        req(1, {10'h022, 10'h005}, 2'b11, 16'hAAAA);
        req(1, {10'h022, 10'h005}, 2'b01, 16'h1234);
        req(0, {10'h022, 10'h005}, 2'b11, 16'h0);
        idle(8);
        chk(last_rd == 16'hAA34, "R5 lower byte only written", last_rd, 16'hAA34);
        req(1, {10'h022, 10'h005}, 2'b10, 16'h5678);
        req(0, {10'h022, 10'h005}, 2'b11, 16'h0);
        idle(8);
        chk(last_rd == 16'h5634, "R5 upper byte only written", last_rd, 16'h5634);

        // R8 row miss forces close and reopen
        f0 = ras_falls;
        req(0, {10'h033, 10'h000}, 2'b11, 16'h0);
        idle(8);
        chk(ras_falls - f0 == 1, "R8 miss reopens row", ras_falls - f0, 1);

        // R9 long same-row stream must be broken before the maximum low time
        f0 = ras_falls;
        for (int i = 0; i < 40; i++) req(i[0], {10'h044, 10'(i % 4)}, 2'b11, 16'(i * 3));
        idle(8);
        chk(ras_falls - f0 >= 2, "R9 long page stream closed", ras_falls - f0, 2);

        // Seeded random traffic over a few rows and columns
        void'($urandom(32'd2024));
        for (int i = 0; i < 300; i++) begin
            logic [9:0] r, c;
            logic [1:0] be;
            r = 10'h100 + 10'($urandom % 3);
            c = 10'($urandom % 8);
            be = 2'(($urandom % 3) + 1);
            if (i % 50 == 0) close_idle = $urandom % 2;
            req($urandom % 2, {r, c}, be, 16'($urandom));
            if ($urandom % 4 == 0) idle($urandom % 4);
        end
        idle(20);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule